// File: doc/BRIEF.md
# Secure-Aware Address-Space-Tagged Translation Buffer

This block is a fully associative translation lookaside buffer that turns a virtual address into a physical address. Each entry is tagged with an 8-bit address-space identifier, a global flag and a world bit that marks the entry as secure or non-secure. Entries of four page sizes (4KB, 64KB, 1MB, 16MB) can sit side by side. A lookup returns hit or miss, the physical address, a 4-bit domain number and a 3-bit permission field. On 4KB and 64KB pages, the permission field is chosen per quarter of the page.

The 64 entries are split into two regions. Entries 0..7 form a lockdown region that is written only at an explicit index. Entries 8..63 form the normal region, which a round-robin victim pointer fills. A configuration input can reserve the lockdown region for the secure world. Invalidation commands remove entries in one of three ways: all entries, entries of one address space, or entries of one virtual page. A global enable bypasses translation completely.

Top module: `tlb_secure_asid`

## Requirements
- R1: A lookup presented with `lkValid` in one cycle is answered on the registered outputs after the next rising edge, with `rspValid` high for exactly that cycle. After reset, every response output is 0 and every entry is invalid.
- R2: Each entry records its page size with the encoding 0=4KB, 1=64KB, 2=1MB, 3=16MB. The virtual page compare ignores the tag bits below the size: none for 4KB, VA[15:12] for 64KB, VA[19:12] for 1MB, VA[23:12] for 16MB.
- R3: An entry with its global flag set matches under any address-space identifier. A non-global entry matches only when its stored identifier equals `lkAsid`.
- R4: An entry matches only when its world bit equals `lkNs` (1 = non-secure). Secure and non-secure entries for the same virtual page therefore coexist.
- R5: On a hit, `rspDomain` is the entry's domain. `rspPerm` is quarter field q of `wrPerm` (bits [3q+2:3q]), where q is VA[11:10] for 4KB pages, VA[15:14] for 64KB pages, and 0 for 1MB and 16MB pages.
- R6: On a hit, the physical address takes the entry's frame bits above the page offset and takes the page-offset bits from the virtual address.
- R7: While `lockSecureOnly` is 1, a write into the lockdown region with `wrNs`=1 is dropped, and a non-secure lookup cannot hit entries 0..7.
- R8: While `mmuEnable` is 0, a lookup reports `rspFlat`=1 and `rspHit`=0, with `rspPa` equal to the virtual address.
- R9: When more than one entry matches, the entry with the lowest index supplies the result and `rspMultiHit` is 1.
- R10: A normal write (`wrLock`=0) goes to the victim pointer. The pointer starts at 8, advances by one after each normal write, and wraps from 63 back to 8. A lockdown write goes to index `wrLockIdx` and does not move the pointer.
- R11: `invOp`=0 invalidates every normal entry. Lockdown entries are invalidated as well only when `invForce` is 1.
- R12: `invOp`=1 invalidates the non-global entries whose identifier equals `invAsid`. `invOp`=2 invalidates the entries whose page covers `invVpn` and that are either global or carry `invAsid`. Both operations spare lockdown entries unless `invForce` is 1, and `invOp`=3 does nothing.
- R13: A lookup in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mmuEnable | input | 1 | Translation enable; 0 gives a flat mapping |
| lockSecureOnly | input | 1 | Reserve the lockdown region for the secure world |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkAsid | input | 8 | Current address-space identifier |
| lkNs | input | 1 | Current world, 1 = non-secure |
| wrValid | input | 1 | Write an entry |
| wrLock | input | 1 | Write into the lockdown region |
| wrLockIdx | input | 3 | Lockdown slot for a lockdown write |
| wrVpn | input | 20 | Virtual page tag VA[31:12] |
| wrFrame | input | 20 | Physical frame PA[31:12] |
| wrAsid | input | 8 | Entry address-space identifier |
| wrGlobal | input | 1 | Entry is global |
| wrNs | input | 1 | Entry world bit |
| wrSize | input | 2 | Page size code |
| wrDomain | input | 4 | Entry domain |
| wrPerm | input | 12 | Four 3-bit quarter permissions; quarter 0 only for sections |
| invValid | input | 1 | Invalidate request |
| invOp | input | 2 | 0 all, 1 by identifier, 2 by page, 3 none |
| invForce | input | 1 | Let the invalidate reach lockdown entries |
| invAsid | input | 8 | Identifier for invalidation |
| invVpn | input | 20 | Page tag for invalidation |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Translation found |
| rspMultiHit | output | 1 | More than one entry matched |
| rspFlat | output | 1 | Translation disabled, flat mapping |
| rspPa | output | 32 | Physical address |
| rspDomain | output | 4 | Domain of the hit entry |
| rspPerm | output | 3 | Selected permission field |

## Verification
A lookup and an entry write can fall in the same cycle. The lookup must see the table as it stood before that edge. The bench provokes this case by writing a new page and looking up the same address in the same cycle. The first response must report a miss, and a lookup one cycle later must hit with the new frame. The tests also cover mixed page sizes, the world and identifier rules, multiple matches, the lockdown restriction, victim pointer wrap-around and every invalidate mode.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int NUM_ENTRIES = 64;
  parameter int NUM_LOCK    = 8;
  parameter int VA_W        = 32;
  parameter int PAGE_SHIFT  = 12;
  parameter int ASID_W      = 8;
  parameter int DOM_W       = 4;
  parameter int PERM_W      = 3;
  parameter int QUARTERS    = 4;
  localparam int TAG_W      = VA_W - PAGE_SHIFT;
  localparam int IDX_W      = $clog2(NUM_ENTRIES);
  localparam int LOCK_IDX_W = $clog2(NUM_LOCK);
  localparam int SIZE_STEP  = 4;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgSize_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_PAGE = 2'd2,
    INV_NONE = 2'd3
  } invOp_e;

  typedef struct packed {
    logic                         valid;
    logic                         global;
    logic                         nsTag;
    logic [ASID_W-1:0]            asid;
    logic [TAG_W-1:0]             vTag;
    logic [TAG_W-1:0]             pFrame;
    pgSize_e                      size;
    logic [DOM_W-1:0]             domain;
    logic [QUARTERS*PERM_W-1:0]   perm;
  } tlbEntry_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             invEn;
    invOp_e           invKind;
    logic             invForce;
  } tlbStrobe_t;

  // Mask of the tag bits that take part in the compare for a page size.
  function automatic logic [TAG_W-1:0] tagMask(input pgSize_e sz);
    return {TAG_W{1'b1}} << (SIZE_STEP * int'(sz));
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lockSecureOnly,
  input  logic                  wrValid,
  input  logic                  wrLock,
  input  logic [LOCK_IDX_W-1:0] wrLockIdx,
  input  logic                  wrNs,
  input  logic                  invValid,
  input  logic [1:0]            invOp,
  input  logic                  invForce,
  output tlbStrobe_t            strobes
);
  localparam logic [IDX_W-1:0] PTR_FIRST = IDX_W'(NUM_LOCK);
  localparam logic [IDX_W-1:0] PTR_LAST  = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] victimPtr;
  logic             normalWr;
  logic             lockBlocked;

  assign normalWr    = wrValid && !wrLock;
  assign lockBlocked = wrLock && lockSecureOnly && wrNs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimPtr <= PTR_FIRST;
    end else if (normalWr) begin
      victimPtr <= (victimPtr == PTR_LAST) ? PTR_FIRST : victimPtr + 1'b1;
    end
  end

  always_comb begin
    strobes.wrEn     = wrValid && !lockBlocked;
    strobes.wrIdx    = wrLock ? IDX_W'(wrLockIdx) : victimPtr;
    strobes.invEn    = invValid && (invOp_e'(invOp) != INV_NONE);
    strobes.invKind  = invOp_e'(invOp);
    strobes.invForce = invForce;
  end

  AST_RR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    victimPtr >= PTR_FIRST && victimPtr <= PTR_LAST); // R10
  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    normalWr |=> victimPtr != $past(victimPtr)); // R10
  AST_LOCK_WR_SECURE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && wrLock && lockSecureOnly) |-> !wrNs); // R7
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       mmuEnable,
  input  logic                       lockSecureOnly,
  input  tlbStrobe_t                 strobes,
  input  logic                       lkValid,
  input  logic [VA_W-1:0]            lkVa,
  input  logic [ASID_W-1:0]          lkAsid,
  input  logic                       lkNs,
  input  logic [TAG_W-1:0]           wrVpn,
  input  logic [TAG_W-1:0]           wrFrame,
  input  logic [ASID_W-1:0]          wrAsid,
  input  logic                       wrGlobal,
  input  logic                       wrNs,
  input  logic [1:0]                 wrSize,
  input  logic [DOM_W-1:0]           wrDomain,
  input  logic [QUARTERS*PERM_W-1:0] wrPerm,
  input  logic [ASID_W-1:0]          invAsid,
  input  logic [TAG_W-1:0]           invVpn,
  output logic                       rspValid,
  output logic                       rspHit,
  output logic                       rspMultiHit,
  output logic                       rspFlat,
  output logic [VA_W-1:0]            rspPa,
  output logic [DOM_W-1:0]           rspDomain,
  output logic [PERM_W-1:0]          rspPerm
);
  tlbEntry_t              entries [NUM_ENTRIES];
  tlbEntry_t              newEntry;
  tlbEntry_t              selEntry;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [NUM_ENTRIES-1:0] killVec;
  logic [IDX_W-1:0]       selIdx;
  logic [TAG_W-1:0]       lkTag;
  logic [TAG_W-1:0]       selMask;
  logic [1:0]             quarter;
  logic                   anyHit;
  logic                   multiHit;
  logic                   doTranslate;

  assign lkTag = lkVa[VA_W-1:PAGE_SHIFT];

  always_comb begin
    newEntry        = '0;
    newEntry.valid  = 1'b1;
    newEntry.global = wrGlobal;
    newEntry.nsTag  = wrNs;
    newEntry.asid   = wrAsid;
    newEntry.vTag   = wrVpn;
    newEntry.pFrame = wrFrame;
    newEntry.size   = pgSize_e'(wrSize);
    newEntry.domain = wrDomain;
    newEntry.perm   = wrPerm;
  end

  // Per-entry match and invalidate decode
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gMatch
    localparam bit IS_LOCK = (g < NUM_LOCK);
    logic [TAG_W-1:0] eMask;
    logic             asidOk;
    logic             hidden;
    logic             kindHit;
    assign eMask   = tagMask(entries[g].size);
    assign asidOk  = entries[g].global || (entries[g].asid == lkAsid);
    assign hidden  = IS_LOCK && lockSecureOnly && lkNs;
    assign hitVec[g] = entries[g].valid && !hidden && asidOk &&
                       (entries[g].nsTag == lkNs) &&
                       ((entries[g].vTag & eMask) == (lkTag & eMask));
    always_comb begin
      unique case (strobes.invKind)
        INV_ALL:  kindHit = 1'b1;
        INV_ASID: kindHit = !entries[g].global && (entries[g].asid == invAsid);
        INV_PAGE: kindHit = ((entries[g].vTag & eMask) == (invVpn & eMask)) &&
                            (entries[g].global || (entries[g].asid == invAsid));
        default:  kindHit = 1'b0;
      endcase
    end
    assign killVec[g] = strobes.invEn && (!IS_LOCK || strobes.invForce) && kindHit;
  end

  // Lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyHit   = |hitVec;
  assign multiHit = |(hitVec & (hitVec - 1'b1));
  assign selEntry = entries[selIdx];
  assign selMask  = tagMask(selEntry.size);

  always_comb begin
    unique case (selEntry.size)
      PG_4K:   quarter = lkVa[11:10];
      PG_64K:  quarter = lkVa[15:14];
      default: quarter = 2'd0;
    endcase
  end

  assign doTranslate = lkValid && mmuEnable && anyHit;

  // Entry storage: a write wins over an invalidate of the same slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entries[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.wrEn && strobes.wrIdx == IDX_W'(i)) begin
          entries[i] <= newEntry;
        end else if (killVec[i]) begin
          entries[i].valid <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspMultiHit <= 1'b0;
      rspFlat     <= 1'b0;
      rspPa       <= '0;
      rspDomain   <= '0;
      rspPerm     <= '0;
    end else begin
      rspValid    <= lkValid;
      rspFlat     <= lkValid && !mmuEnable;
      rspHit      <= doTranslate;
      rspMultiHit <= doTranslate && multiHit;
      if (lkValid && !mmuEnable) begin
        rspPa <= lkVa;
      end else if (doTranslate) begin
        rspPa <= {(selEntry.pFrame & selMask) | (lkTag & ~selMask),
                  lkVa[PAGE_SHIFT-1:0]};
      end else begin
        rspPa <= '0;
      end
      rspDomain <= doTranslate ? selEntry.domain : '0;
      rspPerm   <= doTranslate ? selEntry.perm[quarter*PERM_W +: PERM_W] : '0;
    end
  end

  AST_FLAT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rspFlat |-> rspPa == $past(lkVa)); // R8
  AST_HIT_NOT_FLAT: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (!rspFlat && rspValid)); // R8
  AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspMultiHit |-> rspHit); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lkValid)); // R1
endmodule

// File: rtl/tlb_secure_asid.sv
module tlb_secure_asid
  import tlb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       mmuEnable,
  input  logic                       lockSecureOnly,
  input  logic                       lkValid,
  input  logic [VA_W-1:0]            lkVa,
  input  logic [ASID_W-1:0]          lkAsid,
  input  logic                       lkNs,
  input  logic                       wrValid,
  input  logic                       wrLock,
  input  logic [LOCK_IDX_W-1:0]      wrLockIdx,
  input  logic [TAG_W-1:0]           wrVpn,
  input  logic [TAG_W-1:0]           wrFrame,
  input  logic [ASID_W-1:0]          wrAsid,
  input  logic                       wrGlobal,
  input  logic                       wrNs,
  input  logic [1:0]                 wrSize,
  input  logic [DOM_W-1:0]           wrDomain,
  input  logic [QUARTERS*PERM_W-1:0] wrPerm,
  input  logic                       invValid,
  input  logic [1:0]                 invOp,
  input  logic                       invForce,
  input  logic [ASID_W-1:0]          invAsid,
  input  logic [TAG_W-1:0]           invVpn,
  output logic                       rspValid,
  output logic                       rspHit,
  output logic                       rspMultiHit,
  output logic                       rspFlat,
  output logic [VA_W-1:0]            rspPa,
  output logic [DOM_W-1:0]           rspDomain,
  output logic [PERM_W-1:0]          rspPerm
);
  tlbStrobe_t strobes;

  tlb_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .lockSecureOnly (lockSecureOnly),
    .wrValid        (wrValid),
    .wrLock         (wrLock),
    .wrLockIdx      (wrLockIdx),
    .wrNs           (wrNs),
    .invValid       (invValid),
    .invOp          (invOp),
    .invForce       (invForce),
    .strobes        (strobes)
  );

  tlb_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .mmuEnable      (mmuEnable),
    .lockSecureOnly (lockSecureOnly),
    .strobes        (strobes),
    .lkValid        (lkValid),
    .lkVa           (lkVa),
    .lkAsid         (lkAsid),
    .lkNs           (lkNs),
    .wrVpn          (wrVpn),
    .wrFrame        (wrFrame),
    .wrAsid         (wrAsid),
    .wrGlobal       (wrGlobal),
    .wrNs           (wrNs),
    .wrSize         (wrSize),
    .wrDomain       (wrDomain),
    .wrPerm         (wrPerm),
    .invAsid        (invAsid),
    .invVpn         (invVpn),
    .rspValid       (rspValid),
    .rspHit         (rspHit),
    .rspMultiHit    (rspMultiHit),
    .rspFlat        (rspFlat),
    .rspPa          (rspPa),
    .rspDomain      (rspDomain),
    .rspPerm        (rspPerm)
  );
endmodule

// File: tb/tlb_secure_asid_tb.sv
module tlb_secure_asid_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        mmuEnable, lockSecureOnly, lkValid, lkNs;
  logic [31:0] lkVa;
  logic [7:0]  lkAsid, wrAsid, invAsid;
  logic        wrValid, wrLock, wrGlobal, wrNs, invValid, invForce;
  logic [2:0]  wrLockIdx, rspPerm;
  logic [19:0] wrVpn, wrFrame, invVpn;
  logic [1:0]  wrSize, invOp;
  logic [3:0]  wrDomain, rspDomain;
  logic [11:0] wrPerm;
  logic        rspValid, rspHit, rspMultiHit, rspFlat;
  logic [31:0] rspPa;

  int nTests = 0;
  int nFail  = 0;

  tlb_secure_asid u_dut (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        ns;
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  dom;
    logic [2:0]  perm;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0001_2404, 8'd5,  1'b1, 1'b1, 32'h8000_5404, 4'd3,  3'd2},
    '{32'h0001_2C00, 8'd5,  1'b1, 1'b1, 32'h8000_5C00, 4'd3,  3'd4},
    '{32'h0001_2C00, 8'd6,  1'b1, 1'b0, 32'h0,         4'd0,  3'd0},
    '{32'h0001_2000, 8'd5,  1'b0, 1'b1, 32'hC000_0000, 4'd1,  3'd7},
    '{32'h0004_C123, 8'd99, 1'b1, 1'b1, 32'h9001_C123, 4'd7,  3'd7},
    '{32'h0004_4000, 8'd0,  1'b1, 1'b1, 32'h9001_4000, 4'd7,  3'd5},
    '{32'h0004_C123, 8'd99, 1'b0, 1'b0, 32'h0,         4'd0,  3'd0},
    '{32'h001F_FFFF, 8'd1,  1'b0, 1'b1, 32'hA02F_FFFF, 4'd2,  3'd6},
    '{32'h001F_FFFF, 8'd2,  1'b0, 1'b0, 32'h0,         4'd0,  3'd0},
    '{32'h03AB_CDEF, 8'd7,  1'b1, 1'b1, 32'hB0AB_CDEF, 4'd15, 3'd5},
    '{32'h0400_0000, 8'd7,  1'b1, 1'b0, 32'h0,         4'd0,  3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lkValid = 0; wrValid = 0; invValid = 0;
  endtask

  task automatic setWr(input logic lock, input logic [2:0] idx, input logic [19:0] vpn,
                       input logic [19:0] frame, input logic [7:0] asid, input logic glob,
                       input logic ns, input logic [1:0] sz, input logic [3:0] dom,
                       input logic [11:0] perm);
    wrValid = 1; wrLock = lock; wrLockIdx = idx; wrVpn = vpn; wrFrame = frame;
    wrAsid = asid; wrGlobal = glob; wrNs = ns; wrSize = sz; wrDomain = dom; wrPerm = perm;
  endtask

  task automatic doWr(input logic lock, input logic [2:0] idx, input logic [19:0] vpn,
                      input logic [19:0] frame, input logic [7:0] asid, input logic glob,
                      input logic ns, input logic [1:0] sz, input logic [3:0] dom,
                      input logic [11:0] perm);
    @(negedge clk);
    setWr(lock, idx, vpn, frame, asid, glob, ns, sz, dom, perm);
    @(negedge clk);
    idle();
  endtask

  task automatic setLk(input logic [31:0] va, input logic [7:0] asid, input logic ns);
    lkValid = 1; lkVa = va; lkAsid = asid; lkNs = ns;
  endtask

  // Lookup; outputs are sampled at the negedge after the capturing posedge
  task automatic doLk(input logic [31:0] va, input logic [7:0] asid, input logic ns);
    @(negedge clk);
    setLk(va, asid, ns);
    @(negedge clk);
    idle();
  endtask

  task automatic doInv(input logic [1:0] op, input logic force_, input logic [7:0] asid,
                       input logic [19:0] vpn);
    @(negedge clk);
    invValid = 1; invOp = op; invForce = force_; invAsid = asid; invVpn = vpn;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    mmuEnable = 1; lockSecureOnly = 0; idle();
    lkVa = 0; lkAsid = 0; lkNs = 0;
    wrLock = 0; wrLockIdx = 0; wrVpn = 0; wrFrame = 0; wrAsid = 0; wrGlobal = 0;
    wrNs = 0; wrSize = 0; wrDomain = 0; wrPerm = 0;
    invOp = 0; invForce = 0; invAsid = 0; invVpn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset rspValid", 32'(rspValid), 32'd0);
    chk("R1 reset rspPa", rspPa, 32'd0);
    doLk(32'h0001_2000, 8'd5, 1'b1);
    chk("R1 response valid", 32'(rspValid), 32'd1);
    chk("R1 empty miss", 32'(rspHit), 32'd0);

    // Normal-region entries (indices 8..12)
    doWr(0, 0, 20'h00012, 20'h80005, 8'd5, 0, 1, 2'd0, 4'd3,  {3'd4, 3'd3, 3'd2, 3'd1});
    doWr(0, 0, 20'h00040, 20'h90010, 8'd0, 1, 1, 2'd1, 4'd7,  {3'd7, 3'd6, 3'd5, 3'd4});
    doWr(0, 0, 20'h00100, 20'hA0200, 8'd1, 0, 0, 2'd2, 4'd2,  {3'd0, 3'd0, 3'd0, 3'd6});
    doWr(0, 0, 20'h03000, 20'hB0000, 8'd0, 1, 1, 2'd3, 4'd15, {3'd0, 3'd0, 3'd0, 3'd5});
    doWr(0, 0, 20'h00012, 20'hC0000, 8'd5, 0, 0, 2'd0, 4'd1,  {3'd0, 3'd0, 3'd0, 3'd7});

    // R2 R3 R4 R5 R6 vector table
    for (int v = 0; v < NVEC; v++) begin
      doLk(VECS[v].va, VECS[v].asid, VECS[v].ns);
      chk($sformatf("R3/R4 hit vec%0d", v), 32'(rspHit), 32'(VECS[v].hit));
      if (VECS[v].hit) begin
        chk($sformatf("R2/R6 pa vec%0d", v), rspPa, VECS[v].pa);
        chk($sformatf("R5 domain vec%0d", v), 32'(rspDomain), 32'(VECS[v].dom));
        chk($sformatf("R5 perm vec%0d", v), 32'(rspPerm), 32'(VECS[v].perm));
      end
    end

    // R8 flat mapping
    mmuEnable = 0;
    doLk(32'h1234_5678, 8'd5, 1'b1);
    chk("R8 flat", 32'(rspFlat), 32'd1);
    chk("R8 no hit", 32'(rspHit), 32'd0);
    chk("R8 pa", rspPa, 32'h1234_5678);
    mmuEnable = 1;

    // R9 multi-hit with lockdown slot 2
    doWr(1, 3'd2, 20'h00012, 20'hD0000, 8'd0, 1, 1, 2'd0, 4'd4, {3'd0, 3'd0, 3'd0, 3'd1});
    doLk(32'h0001_2000, 8'd5, 1'b1);
    chk("R9 lowest index pa", rspPa, 32'hD000_0000);
    chk("R9 multi flag", 32'(rspMultiHit), 32'd1);

    // R7 lockdown reserved for secure world
    lockSecureOnly = 1;
    doLk(32'h0001_2000, 8'd5, 1'b1);
    chk("R7 lockdown hidden pa", rspPa, 32'h8000_5000);
    chk("R7 lockdown hidden multi", 32'(rspMultiHit), 32'd0);
    doWr(1, 3'd3, 20'h00500, 20'hE0000, 8'd0, 1, 1, 2'd2, 4'd0, 12'd0);
    doWr(1, 3'd4, 20'h00600, 20'hE1000, 8'd0, 1, 0, 2'd2, 4'd0, 12'd0);
    doLk(32'h0060_0000, 8'd0, 1'b0);
    chk("R7 secure lockdown write kept", rspPa, 32'hE100_0000);
    lockSecureOnly = 0;
    doLk(32'h0050_0000, 8'd0, 1'b1);
    chk("R7 non-secure lockdown write dropped", 32'(rspHit), 32'd0);

    // R13 write and lookup of the same page in one cycle
    @(negedge clk);
    setWr(0, 0, 20'h00700, 20'hF0000, 8'd0, 1, 1, 2'd0, 4'd0, 12'd0);
    setLk(32'h0070_0000, 8'd0, 1'b1);
    @(negedge clk);
    idle();
    chk("R13 same-cycle sees old", 32'(rspHit), 32'd0);
    doLk(32'h0070_0000, 8'd0, 1'b1);
    chk("R13 next cycle sees new", rspPa, 32'hF000_0000);

    // R12 invalidate by identifier
    doInv(2'd1, 0, 8'd5, 20'h0);
    doLk(32'h0001_2000, 8'd5, 1'b0);
    chk("R12 asid inval non-global", 32'(rspHit), 32'd0);
    doLk(32'h0004_0000, 8'd5, 1'b1);
    chk("R12 asid inval spares global", 32'(rspHit), 32'd1);
    doLk(32'h0001_2000, 8'd5, 1'b1);
    chk("R12 lockdown survives asid inval", rspPa, 32'hD000_0000);
    chk("R12 only lockdown left", 32'(rspMultiHit), 32'd0);

    // R12 invalidate by page
    doInv(2'd2, 0, 8'd0, 20'h03000);
    doLk(32'h03AB_CDEF, 8'd7, 1'b1);
    chk("R12 page inval global 16MB", 32'(rspHit), 32'd0);
    doLk(32'h001F_FFFF, 8'd1, 1'b0);
    chk("R12 page inval spares other", 32'(rspHit), 32'd1);
    doInv(2'd3, 1, 8'd1, 20'h00100);
    doLk(32'h001F_FFFF, 8'd1, 1'b0);
    chk("R12 op 3 no effect", 32'(rspHit), 32'd1);

    // R10 round-robin: pointer is at 14; 56 writes wrap back to 14
    for (int i = 0; i < 56; i++) begin
      doWr(0, 0, 20'h10000 + 20'(i), 20'h20000 + 20'(i), 8'd0, 1, 1, 2'd0, 4'd0, 12'd0);
    end
    doWr(0, 0, 20'h30000, 20'h40000, 8'd0, 1, 1, 2'd0, 4'd0, 12'd0);
    doLk(32'h1000_0000, 8'd0, 1'b1);
    chk("R10 oldest evicted", 32'(rspHit), 32'd0);
    doLk(32'h1000_1000, 8'd0, 1'b1);
    chk("R10 next kept", rspPa, 32'h2000_1000);
    doLk(32'h3000_0000, 8'd0, 1'b1);
    chk("R10 new entry", rspPa, 32'h4000_0000);
    doLk(32'h0001_2000, 8'd0, 1'b1);
    chk("R10 lockdown not evicted", rspPa, 32'hD000_0000);

    // R11 invalidate all
    doInv(2'd0, 0, 8'd0, 20'h0);
    doLk(32'h0001_2000, 8'd0, 1'b1);
    chk("R11 lockdown kept", rspPa, 32'hD000_0000);
    doLk(32'h3000_0000, 8'd0, 1'b1);
    chk("R11 normal cleared", 32'(rspHit), 32'd0);
    doInv(2'd0, 1, 8'd0, 20'h0);
    doLk(32'h0001_2000, 8'd0, 1'b1);
    chk("R11 forced clears lockdown", 32'(rspHit), 32'd0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule